// File: doc/BRIEF.md
# Configuration Latch Bank

This block holds three small configuration words that all arrive over one shared 2-bit bus. The three words are the serial driver enables, the transmit and receive self-test enables, and the receive-path power enable. Each word has its own active-high load strobe. The block is clocked. In every cycle where a strobe is high, its register follows the bus. In the first cycle where the strobe is low, the register holds the value it took last. A synchronous reset returns a register to its safe value only while that register's strobe is low. A register whose strobe is high keeps loading the bus during reset.

The bus bits do not have the same meaning in every register. For the driver enables and for receive power, a 1 turns the function on. For self-test, a 0 turns it on. The block also drives an active-low link-fault flag. The flag is asserted when any of three receive status inputs is high, or when the receive path is powered down according to the power register.

Top module: `cfg_latch_bank`

## Requirements
- R1: After reset with all strobes low, drv_en is 00, tx_bist_en and rx_bist_en are 0, rx_pwr_en is 0, and link_fault_n is 0.
- R2: If oe_stb is high at a clock edge, then after that edge drv_en[i] equals cfg_bus[i] as sampled at the edge (1 = driver on, 0 = powered down).
- R3: A register whose strobe is low at an edge keeps its value (reset excepted). A change on cfg_bus while the strobe is low has no effect on it.
- R4: If bist_stb is high at an edge, then after that edge rx_bist_en = NOT cfg_bus[0] and tx_bist_en = NOT cfg_bus[1]. A bus bit of 0 enables self-test.
- R5: If rxpwr_stb is high at an edge, then after that edge rx_pwr_en equals cfg_bus[0]; cfg_bus[1] is ignored.
- R6: If rst is high at an edge while a strobe is low, that register goes to its safe value: drivers off, self-test off on both channels, receive power off. A register whose strobe is high at that edge loads the bus instead.
- R7: If freq_err, amp_low or dens_low is high at an edge, link_fault_n is 0 after that edge.
- R8: If rx_pwr_en is 0 at an edge, link_fault_n is 0 after that edge. When rx_pwr_en is 1 and no status input is high, link_fault_n is 1. link_fault_n is registered, so it follows rx_pwr_en one cycle later.
- R9: If several strobes are high at the same edge, every register whose strobe is high loads the same bus value.
- R10: A strobe affects only its own register; the other registers hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bus | input | 2 | Shared configuration bus |
| oe_stb | input | 1 | Load strobe for the driver-enable register |
| bist_stb | input | 1 | Load strobe for the self-test register |
| rxpwr_stb | input | 1 | Load strobe for the receive-power register |
| freq_err | input | 1 | Received frequency out of range |
| amp_low | input | 1 | Received amplitude too low |
| dens_low | input | 1 | Transition density too low |
| drv_en | output | 2 | Serial driver enables, bit i drives output i |
| tx_bist_en | output | 1 | Transmit self-test active |
| rx_bist_en | output | 1 | Receive self-test active |
| rx_pwr_en | output | 1 | Receive PLL and analog path powered |
| link_fault_n | output | 1 | Link fault, active low |

## Verification
The hardest case to reach is the overlap of reset with open strobes. Here some registers must return to their safe values while others, in the same cycle, keep loading the bus. Such mixes seldom come up in normal use.

The bench sweeps every combination of reset, the three strobes and the four bus values, twice. Between the sweeps the status inputs and the register contents differ, so every open/closed and reset/no-reset pairing is seen for each register. The bench also checks the one-cycle lag between the power register and the fault flag against its own model.

// File: rtl/cfg_latch_pkg.sv
package cfg_latch_pkg;
  localparam int CH_N   = 2;
  localparam int RX_IDX = 0;
  localparam int TX_IDX = 1;
  // safe values of the stored bus words
  localparam logic [CH_N-1:0] OE_SAFE   = '0;
  localparam logic [CH_N-1:0] BIST_SAFE = '1;
  localparam logic            PWR_SAFE  = 1'b0;
endpackage

// File: rtl/cfg_strobe_latch.sv
module cfg_strobe_latch #(
  parameter int           W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         stb,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (stb)      q <= d;
    else if (rst) q <= RST_VAL;
  end

  // R2
  load_follow_chk: assert property (@(posedge clk) disable iff (rst)
    stb |=> q == $past(d));
  // R3
  hold_closed_chk: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(q));
  // R6
  rst_closed_chk: assert property (@(posedge clk)
    (rst && !stb) |=> q == RST_VAL);
endmodule

// File: rtl/cfg_link_fault.sv
module cfg_link_fault #(
  parameter int N_TERM = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_TERM-1:0] terms,
  output logic              fault_n
);
  always_ff @(posedge clk) begin
    if (rst) fault_n <= 1'b0;
    else     fault_n <= ~(|terms);
  end
endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank
  import cfg_latch_pkg::*;
#(
  parameter int BUS_W = CH_N
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BUS_W-1:0] cfg_bus,
  input  logic             oe_stb,
  input  logic             bist_stb,
  input  logic             rxpwr_stb,
  input  logic             freq_err,
  input  logic             amp_low,
  input  logic             dens_low,
  output logic [BUS_W-1:0] drv_en,
  output logic             tx_bist_en,
  output logic             rx_bist_en,
  output logic             rx_pwr_en,
  output logic             link_fault_n
);
  localparam int N_TERM = 4;

  logic [BUS_W-1:0] oe_q, bist_q;
  logic [0:0]       pwr_q;
  logic [N_TERM-1:0] fault_terms;

  cfg_strobe_latch #(.W(BUS_W), .RST_VAL(OE_SAFE)) oe_lat_i (
    .clk(clk), .rst(rst), .stb(oe_stb), .d(cfg_bus), .q(oe_q));

  cfg_strobe_latch #(.W(BUS_W), .RST_VAL(BIST_SAFE)) bist_lat_i (
    .clk(clk), .rst(rst), .stb(bist_stb), .d(cfg_bus), .q(bist_q));

  cfg_strobe_latch #(.W(1), .RST_VAL(PWR_SAFE)) pwr_lat_i (
    .clk(clk), .rst(rst), .stb(rxpwr_stb), .d(cfg_bus[RX_IDX]), .q(pwr_q));

  assign drv_en     = oe_q;
  assign tx_bist_en = ~bist_q[TX_IDX];
  assign rx_bist_en = ~bist_q[RX_IDX];
  assign rx_pwr_en  = pwr_q[0];

  assign fault_terms = {~pwr_q[0], dens_low, amp_low, freq_err};

  cfg_link_fault #(.N_TERM(N_TERM)) fault_i (
    .clk(clk), .rst(rst), .terms(fault_terms), .fault_n(link_fault_n));

  // R4
  bist_pol_chk: assert property (@(posedge clk) disable iff (rst)
    (bist_stb && !cfg_bus[RX_IDX]) |=> rx_bist_en);
  // R5
  rxpwr_load_chk: assert property (@(posedge clk) disable iff (rst)
    rxpwr_stb |=> rx_pwr_en == $past(cfg_bus[RX_IDX]));
  // R7
  status_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (freq_err || amp_low || dens_low) |=> !link_fault_n);
  // R8
  pwr_off_fault_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_pwr_en |=> !link_fault_n);
  // R10
  oe_indep_chk: assert property (@(posedge clk) disable iff (rst)
    (!oe_stb && (bist_stb || rxpwr_stb)) |=> $stable(drv_en));
endmodule

// File: tb/cfg_latch_bank_tb.sv
module cfg_latch_bank_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cfg_bus = '0;
  logic       oe_stb = 0, bist_stb = 0, rxpwr_stb = 0;
  logic       freq_err = 0, amp_low = 0, dens_low = 0;
  logic [1:0] drv_en;
  logic       tx_bist_en, rx_bist_en, rx_pwr_en, link_fault_n;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [1:0] m_oe, m_bist;
  logic       m_pwr, m_lfi;

  always #2.5 clk = ~clk;

  cfg_latch_bank dut_i (
    .clk(clk), .rst(rst), .cfg_bus(cfg_bus), .oe_stb(oe_stb),
    .bist_stb(bist_stb), .rxpwr_stb(rxpwr_stb), .freq_err(freq_err),
    .amp_low(amp_low), .dens_low(dens_low), .drv_en(drv_en),
    .tx_bist_en(tx_bist_en), .rx_bist_en(rx_bist_en),
    .rx_pwr_en(rx_pwr_en), .link_fault_n(link_fault_n));

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string lbl(input logic own, input int nopen, input logic r,
                                input string open_req);
    if (own) return (nopen > 1) ? "R9" : open_req;
    if (r)   return "R6";
    return (nopen > 0) ? "R10" : "R3";
  endfunction

  // drive at negedge, compute expectations, clock, check at next negedge
  task automatic step(input logic r, input logic [2:0] s, input logic [1:0] b,
                      input logic [2:0] st);
    int nopen;
    rst = r; oe_stb = s[0]; bist_stb = s[1]; rxpwr_stb = s[2]; cfg_bus = b;
    {dens_low, amp_low, freq_err} = st;
    nopen = s[0] + s[1] + s[2];
    // fault flag uses power state before this edge
    m_lfi = r ? 1'b0 : ~((|st) | ~m_pwr);
    if (s[0]) m_oe = b;   else if (r) m_oe = 2'b00;
    if (s[1]) m_bist = b; else if (r) m_bist = 2'b11;
    if (s[2]) m_pwr = b[0]; else if (r) m_pwr = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(lbl(s[0], nopen, r, "R2"), drv_en, m_oe);
    chk(lbl(s[1], nopen, r, "R4"), {tx_bist_en, rx_bist_en}, ~m_bist);
    chk(lbl(s[2], nopen, r, "R5"), {1'b0, rx_pwr_en}, {1'b0, m_pwr});
    chk((|st) ? "R7" : "R8", {1'b0, link_fault_n}, {1'b0, m_lfi});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    m_oe = 2'b00; m_bist = 2'b11; m_pwr = 1'b0; m_lfi = 1'b0;
    // R1 reset state
    chk("R1", drv_en, 2'b00);
    chk("R1", {tx_bist_en, rx_bist_en}, 2'b00);
    chk("R1", {1'b0, rx_pwr_en}, 2'b00);
    chk("R1", {1'b0, link_fault_n}, 2'b00);
    rst = 0;
    // exhaustive sweeps over reset x strobes x bus, two status patterns
    for (int pass = 0; pass < 2; pass++)
      for (int r = 0; r < 2; r++)
        for (int s = 0; s < 8; s++)
          for (int b = 0; b < 4; b++)
            step(r[0], s[2:0], b[1:0],
                 (pass == 0) ? 3'b000 : ((b == 3) ? 3'b000 : 3'(1 << b)));
    // R8: power up with clean status clears fault one cycle after power
    step(1'b0, 3'b100, 2'b01, 3'b000);
    step(1'b0, 3'b000, 2'b10, 3'b000);
    // R3: bus toggles while closed
    step(1'b0, 3'b000, 2'b00, 3'b000);
    step(1'b0, 3'b000, 2'b11, 3'b000);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule